// File: doc/BRIEF.md
# Clock-Crossing Timer Register Bridge

This block sits between a processor register bus, clocked by a bus clock, and the register file of a timer-style peripheral that runs on its own core clock with no phase or frequency relation to the bus. Some writes and some reads have to reach the core clock domain before they take effect. The bridge carries each of them across with a toggle request and acknowledge handshake. While a crossing is under way it shows a busy status bit. When the crossing is over it raises a ready flag, which can drive an interrupt.

Writes that cross are posted. The bus access finishes at once and the core register changes a few core cycles later. If a second access that must cross arrives before the first has finished, the bridge holds the bus in a wait state rather than drop it. A read of a core-domain register always waits for its own crossing and then returns the value captured in the core domain. Status, flag and interrupt-enable registers live on the bus side and never stall.

Register addresses, with the word address in `bus_addr`: 0 control (bit0 software reset, bit1 enable), 1 config set, 2 config clear, 3 mode, 4 status, 5 ready flag, 6 interrupt-enable set, 7 interrupt-enable clear, 8 count, 9 period, 10 onward one compare/capture register each. Addresses above the last compare/capture register are unmapped.

Top module: `sync_regbridge`

## Requirements
- R1: A write or read that must cross (writes to 0,1,2,3,8,9,10..10+NCC-1; reads of 1,2,3,8,9,10..10+NCC-1) sets busy (status bit0) at the clock edge that accepts it, so an access in the very next cycle already reads busy=1. Busy stays 1 until the crossing is acknowledged, then returns to 0.
- R2: Each finished crossing sets the ready flag (address 5, bit0). Writing 1 to bit0 clears it, and writing 0 leaves it unchanged.
- R3: A crossing access that arrives while busy=1 is held with bus_wait=1 until the earlier crossing is over, then completes. Back-to-back writes all reach the core register, in the order they were issued.
- R4: A write to config set ORs the data into the core config register, and a write to config clear clears the bits where the data is 1. A read of either address returns the core config value.
- R5: A read of a core-domain register holds bus_wait=1 until its own crossing is over, then returns the value the core register holds.
- R6: Writes to count (8), period (9) and each compare/capture register (10+i) reach the matching core output, and a read of the same address returns that value.
- R7: Accesses to status, ready flag, the interrupt-enable addresses, reads of control, and unmapped addresses complete with bus_wait=0.
- R8: irq is 1 only when both the ready flag and the interrupt enable are 1. Writing bit0=1 to address 6 sets the enable, writing bit0=1 to address 7 clears it, and a read of either returns the enable in bit0.
- R9: A control write with bit1=1 and bit0=0 sets core_enable. A control write with bit0=1 returns every core register to 0, and busy stays 1 until that reset has been acknowledged.
- R10: Unmapped addresses read as 0, and a write to one changes no core register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst | input | 1 | Synchronous active-high reset, bus domain |
| cclk | input | 1 | Core clock |
| crst | input | 1 | Synchronous active-high reset, core domain |
| bus_sel | input | 1 | Access present; held until it completes |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the completing cycle |
| bus_wait | output | 1 | Access is stalled this cycle |
| irq | output | 1 | Ready interrupt |
| core_enable | output | 1 | Core enable bit |
| core_cfg | output | DW | Core config register |
| core_mode | output | DW | Core mode register |
| core_count | output | DW | Core count register |
| core_period | output | DW | Core period register |
| core_cc | output | NCC*DW | Compare/capture registers, entry i at bits i*DW |

## Verification
The assertions assume that the bus master keeps address, direction and data steady while bus_wait is high, and that it raises bus_sel only for whole accesses. The bench drives every input at the falling bus edge and leaves an access unchanged until it sees bus_wait low just before a rising edge. Both resets are applied together, so the request and acknowledge toggles start out equal. The clocks have periods of 20 ns and 26 ns, so crossings land at shifting phases, and no check depends on an exact crossing latency; the bench only relies on busy being visible in the cycle after the accepting edge.

// File: rtl/sync_regbridge_pkg.sv
package sync_regbridge_pkg;
  localparam int A_CTRL   = 0;
  localparam int A_CFGSET = 1;
  localparam int A_CFGCLR = 2;
  localparam int A_MODE   = 3;
  localparam int A_STATUS = 4;
  localparam int A_IFLAG  = 5;
  localparam int A_IENSET = 6;
  localparam int A_IENCLR = 7;
  localparam int A_COUNT  = 8;
  localparam int A_PERIOD = 9;
  localparam int A_CC0    = 10;

  // True when an access at address a must cross into the core domain
  function automatic logic needs_sync(input int a, input logic wr, input int ncc);
    logic core_reg;
    core_reg = (a == A_CFGSET) || (a == A_CFGCLR) || (a == A_MODE) ||
               (a == A_COUNT) || (a == A_PERIOD) ||
               ((a >= A_CC0) && (a < A_CC0 + ncc));
    return core_reg || (wr && (a == A_CTRL));
  endfunction
endpackage

// File: rtl/srb_sync2.sv
module srb_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/srb_bus_ctrl.sv
module srb_bus_ctrl
  import sync_regbridge_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 4,
  parameter int NCC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_wait,
  output logic          irq,
  input  logic          ack_s,
  input  logic [DW-1:0] core_rd,
  output logic          req_tgl,
  output logic          cmd_wr,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_wdata,
  output logic          busy,
  output logic          launch,
  output logic          done,
  output logic          flag,
  output logic          ien
);
  int          a;
  logic        sync_acc;
  logic        acc_ok;
  logic        rd_ready;
  logic        en_shadow;
  logic [DW-1:0] rd_cap;

  assign a        = int'(bus_addr);
  assign sync_acc = needs_sync(a, bus_wr, NCC);
  assign done     = busy && (ack_s == req_tgl);
  assign bus_wait = bus_sel && sync_acc && (busy || (!bus_wr && !rd_ready));
  assign launch   = bus_sel && sync_acc && !busy && (bus_wr || !rd_ready);
  assign acc_ok   = bus_sel && !bus_wait;
  assign irq      = flag && ien;

  // Request side of the handshake: command held while busy
  always_ff @(posedge clk) begin
    if (rst) begin
      req_tgl   <= 1'b0;
      busy      <= 1'b0;
      cmd_wr    <= 1'b0;
      cmd_addr  <= '0;
      cmd_wdata <= '0;
    end else if (launch) begin
      req_tgl   <= ~req_tgl;
      busy      <= 1'b1;
      cmd_wr    <= bus_wr;
      cmd_addr  <= bus_addr;
      cmd_wdata <= bus_wdata;
    end else if (done) begin
      busy <= 1'b0;
    end
  end

  // Read return: captured when a read crossing finishes
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ready <= 1'b0;
      rd_cap   <= '0;
    end else if (done && !cmd_wr) begin
      rd_ready <= 1'b1;
      rd_cap   <= core_rd;
    end else if (acc_ok && sync_acc && !bus_wr) begin
      rd_ready <= 1'b0;
    end
  end

  // Ready flag, interrupt enable and enable shadow
  always_ff @(posedge clk) begin
    if (rst) begin
      flag      <= 1'b0;
      ien       <= 1'b0;
      en_shadow <= 1'b0;
    end else begin
      if (done)
        flag <= 1'b1;
      else if (acc_ok && bus_wr && (a == A_IFLAG) && bus_wdata[0])
        flag <= 1'b0;
      if (acc_ok && bus_wr && (a == A_IENSET) && bus_wdata[0])
        ien <= 1'b1;
      else if (acc_ok && bus_wr && (a == A_IENCLR) && bus_wdata[0])
        ien <= 1'b0;
      if (launch && bus_wr && (a == A_CTRL))
        en_shadow <= bus_wdata[0] ? 1'b0 : bus_wdata[1];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sync_acc && !bus_wr) begin
      bus_rdata = rd_cap;
    end else begin
      case (a)
        A_CTRL:   bus_rdata[1] = en_shadow;
        A_STATUS: bus_rdata[0] = busy;
        A_IFLAG:  bus_rdata[0] = flag;
        A_IENSET,
        A_IENCLR: bus_rdata[0] = ien;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/srb_core_regs.sv
module srb_core_regs
  import sync_regbridge_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 4,
  parameter int NCC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_tgl,
  input  logic              cmd_wr,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [DW-1:0]     cmd_wdata,
  output logic              ack_tgl,
  output logic [DW-1:0]     rd_hold,
  output logic              core_enable,
  output logic [DW-1:0]     core_cfg,
  output logic [DW-1:0]     core_mode,
  output logic [DW-1:0]     core_count,
  output logic [DW-1:0]     core_period,
  output logic [NCC*DW-1:0] core_cc
);
  logic req_s;
  logic req_seen;
  logic act;
  logic wr_act;
  logic swrst_act;
  int   ca;
  logic [DW-1:0] rd_val;

  srb_sync2 #(.W(1)) u_req_sync (.clk(clk), .rst(rst), .d(req_tgl), .q(req_s));

  assign act       = req_s != req_seen;
  assign ca        = int'(cmd_addr);
  assign wr_act    = act && cmd_wr;
  assign swrst_act = wr_act && (ca == A_CTRL) && cmd_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      req_seen <= 1'b0;
      ack_tgl  <= 1'b0;
      rd_hold  <= '0;
    end else if (act) begin
      req_seen <= req_s;
      ack_tgl  <= req_s;
      if (!cmd_wr)
        rd_hold <= rd_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || swrst_act) begin
      core_enable <= 1'b0;
      core_cfg    <= '0;
      core_mode   <= '0;
      core_count  <= '0;
      core_period <= '0;
    end else if (wr_act) begin
      case (ca)
        A_CTRL:   core_enable <= cmd_wdata[1];
        A_CFGSET: core_cfg    <= core_cfg | cmd_wdata;
        A_CFGCLR: core_cfg    <= core_cfg & ~cmd_wdata;
        A_MODE:   core_mode   <= cmd_wdata;
        A_COUNT:  core_count  <= cmd_wdata;
        A_PERIOD: core_period <= cmd_wdata;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NCC; g++) begin : g_cc
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst || swrst_act)
        q <= '0;
      else if (wr_act && (ca == A_CC0 + g))
        q <= cmd_wdata;
    end
    assign core_cc[g*DW +: DW] = q;
  end

  always_comb begin
    rd_val = '0;
    case (ca)
      A_CFGSET, A_CFGCLR: rd_val = core_cfg;
      A_MODE:             rd_val = core_mode;
      A_COUNT:            rd_val = core_count;
      A_PERIOD:           rd_val = core_period;
      default: begin
        for (int i = 0; i < NCC; i++)
          if (ca == A_CC0 + i) rd_val = core_cc[i*DW +: DW];
      end
    endcase
  end
endmodule

// File: rtl/sync_regbridge.sv
module sync_regbridge
  import sync_regbridge_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 4,
  parameter int NCC = 4
) (
  input  logic              bclk,
  input  logic              brst,
  input  logic              cclk,
  input  logic              crst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_wait,
  output logic              irq,
  output logic              core_enable,
  output logic [DW-1:0]     core_cfg,
  output logic [DW-1:0]     core_mode,
  output logic [DW-1:0]     core_count,
  output logic [DW-1:0]     core_period,
  output logic [NCC*DW-1:0] core_cc
);
  logic          req_tgl;
  logic          ack_tgl;
  logic          ack_s;
  logic          cmd_wr;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic [DW-1:0] rd_hold;
  logic          busy;
  logic          launch;
  logic          done;
  logic          flag;
  logic          ien;

  srb_bus_ctrl #(.DW(DW), .AW(AW), .NCC(NCC)) u_bus (
    .clk(bclk), .rst(brst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_wait(bus_wait), .irq(irq),
    .ack_s(ack_s), .core_rd(rd_hold),
    .req_tgl(req_tgl), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .busy(busy), .launch(launch), .done(done), .flag(flag), .ien(ien)
  );

  srb_sync2 #(.W(1)) u_ack_sync (.clk(bclk), .rst(brst), .d(ack_tgl), .q(ack_s));

  srb_core_regs #(.DW(DW), .AW(AW), .NCC(NCC)) u_core (
    .clk(cclk), .rst(crst),
    .req_tgl(req_tgl), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .ack_tgl(ack_tgl), .rd_hold(rd_hold),
    .core_enable(core_enable), .core_cfg(core_cfg), .core_mode(core_mode),
    .core_count(core_count), .core_period(core_period), .core_cc(core_cc)
  );
endmodule

// File: rtl/sync_regbridge_chk.sv
module sync_regbridge_chk
  import sync_regbridge_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 4,
  parameter int NCC = 4
) (
  input logic          bclk,
  input logic          brst,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wait,
  input logic          irq,
  input logic          busy,
  input logic          launch,
  input logic          done,
  input logic          flag,
  input logic          ien,
  input logic          req_tgl,
  input logic [DW-1:0] cmd_wdata
);
  logic sync_acc;
  assign sync_acc = needs_sync(int'(bus_addr), bus_wr, NCC);

  a_r1_busy_after_launch: assert property (@(posedge bclk) disable iff (brst)
    launch |=> busy);

  a_r1_busy_held: assert property (@(posedge bclk) disable iff (brst)
    busy && !done |=> busy);

  a_r2_flag_after_done: assert property (@(posedge bclk) disable iff (brst)
    done |=> flag);

  a_r3_cmd_stable: assert property (@(posedge bclk) disable iff (brst)
    busy && !done |=> $stable(cmd_wdata) && $stable(req_tgl));

  a_r3_stall_when_busy: assert property (@(posedge bclk) disable iff (brst)
    bus_sel && sync_acc && busy |-> bus_wait);

  a_r7_no_wait_local: assert property (@(posedge bclk) disable iff (brst)
    bus_sel && !sync_acc |-> !bus_wait);

  a_r8_irq_needs_enable: assert property (@(posedge bclk) disable iff (brst)
    !ien |-> !irq);
endmodule

bind sync_regbridge sync_regbridge_chk #(.DW(DW), .AW(AW), .NCC(NCC)) u_chk (
  .bclk(bclk), .brst(brst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wait(bus_wait), .irq(irq), .busy(busy), .launch(launch), .done(done),
  .flag(flag), .ien(ien), .req_tgl(req_tgl), .cmd_wdata(cmd_wdata)
);

// File: tb/sync_regbridge_test.sv
`timescale 1ns/1ps
module sync_regbridge_test;
  localparam int DW = 16, AW = 4, NCC = 4;
  localparam int HB = 10;   // 50 MHz bus clock
  localparam int HC = 13;   // unrelated core clock

  logic bclk = 0, cclk = 0, brst = 1, crst = 1;
  logic bus_sel = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic bus_wait, irq, core_enable;
  logic [DW-1:0] core_cfg, core_mode, core_count, core_period;
  logic [NCC*DW-1:0] core_cc;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [DW-1:0] exp_cnt_q[$];
  logic [DW-1:0] prev_cnt = '0;

  always #HB bclk = ~bclk;
  always #HC cclk = ~cclk;

  sync_regbridge #(.DW(DW), .AW(AW), .NCC(NCC)) uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Per-clock ordering monitor on the core count register
  always @(negedge cclk) begin
    if (!crst && core_count !== prev_cnt) begin
      if (exp_cnt_q.size() == 0) begin
        chk(0, "R3", "unexpected count change", core_count, prev_cnt);
      end else begin
        logic [DW-1:0] e;
        e = exp_cnt_q.pop_front();
        chk(core_count == e, "R3", "count order", core_count, e);
      end
      prev_cnt = core_count;
    end
  end

  task automatic acc(input logic wr, input int a, input logic [DW-1:0] d,
                     output logic [DW-1:0] rd, output int nw);
    nw = 0;
    @(negedge bclk);
    bus_sel = 1; bus_wr = wr; bus_addr = AW'(a); bus_wdata = d;
    #(HB-2);
    while (bus_wait && nw < 2000) begin
      nw++;
      @(negedge bclk);
      #(HB-2);
    end
    rd = bus_rdata;
    @(posedge bclk);
    #1 bus_sel = 0;
  endtask

  task automatic wr_cnt(input logic [DW-1:0] v, output int nw);
    logic [DW-1:0] r;
    exp_cnt_q.push_back(v);
    acc(1, 8, v, r, nw);
  endtask

  task automatic idle();
    logic [DW-1:0] r;
    int nw;
    int n = 0;
    do begin acc(0, 4, 0, r, nw); n++; end while (r[0] && n < 200);
    repeat (4) @(posedge cclk);
  endtask

  initial begin
    repeat (200000) @(posedge bclk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r;
    int nw, nw2, nw3;
    repeat (4) @(posedge cclk);
    @(negedge bclk); brst = 0; crst = 0;
    repeat (3) @(negedge bclk);

    // Reset state
    chk(bus_wait == 0 && irq == 0, "R8", "reset wait/irq", {bus_wait, irq}, 0);
    chk(core_count == 0 && core_cfg == 0 && core_enable == 0, "R9", "reset core regs", core_count, 0);
    acc(0, 4, 0, r, nw);
    chk(r == 0 && nw == 0, "R7", "status read no wait", nw, 0);

    // R1 busy visible the cycle after the accepting edge
    wr_cnt(16'h1234, nw);
    chk(nw == 0, "R1", "first write not stalled", nw, 0);
    acc(0, 4, 0, r, nw2);
    chk(r[0] == 1, "R1", "busy after launch", r[0], 1);
    chk(nw2 == 0, "R7", "status read while busy", nw2, 0);
    idle();
    acc(0, 4, 0, r, nw);
    chk(r[0] == 0, "R1", "busy clears", r[0], 0);
    chk(core_count == 16'h1234, "R6", "count reached core", core_count, 16'h1234);

    // R2 ready flag
    acc(0, 5, 0, r, nw);
    chk(r[0] == 1, "R2", "flag set", r[0], 1);
    acc(1, 5, 0, r, nw);
    acc(0, 5, 0, r, nw);
    chk(r[0] == 1, "R2", "write 0 keeps flag", r[0], 1);
    acc(1, 5, 1, r, nw);
    acc(0, 5, 0, r, nw);
    chk(r[0] == 0, "R2", "write 1 clears flag", r[0], 0);

    // R3 back-to-back stalls and ordering
    wr_cnt(16'hA001, nw);
    wr_cnt(16'hA002, nw2);
    wr_cnt(16'hA003, nw3);
    chk(nw == 0, "R3", "first of burst", nw, 0);
    chk(nw2 > 0, "R3", "second write stalled", nw2, 1);
    chk(nw3 > 0, "R3", "third write stalled", nw3, 1);
    idle();
    chk(core_count == 16'hA003, "R3", "last value in core", core_count, 16'hA003);
    chk(exp_cnt_q.size() == 0, "R3", "all writes seen", exp_cnt_q.size(), 0);

    // R8 interrupt enable
    acc(1, 5, 1, r, nw);
    acc(1, 6, 1, r, nw);
    @(negedge bclk);
    chk(irq == 0, "R8", "no irq without flag", irq, 0);
    acc(0, 6, 0, r, nw);
    chk(r[0] == 1, "R8", "enable reads back", r[0], 1);
    acc(1, 9, 16'h0777, r, nw);
    idle();
    @(negedge bclk);
    chk(irq == 1, "R8", "irq with flag and enable", irq, 1);
    acc(1, 7, 1, r, nw);
    @(negedge bclk);
    chk(irq == 0, "R8", "irq off after enable clear", irq, 0);
    acc(1, 5, 1, r, nw);

    // R5 synchronized read
    acc(0, 9, 0, r, nw);
    chk(r == 16'h0777, "R5", "period read value", r, 16'h0777);
    chk(nw > 0, "R5", "read stalled", nw, 1);

    // R4 set/clear config
    acc(1, 1, 16'h00F0, r, nw);
    acc(1, 1, 16'h0F00, r, nw);
    idle();
    chk(core_cfg == 16'h0FF0, "R4", "cfg set", core_cfg, 16'h0FF0);
    acc(1, 2, 16'h00F0, r, nw);
    acc(0, 1, 0, r, nw);
    chk(r == 16'h0F00, "R4", "cfg clear via read", r, 16'h0F00);
    acc(1, 3, 16'h0005, r, nw);
    acc(0, 3, 0, r, nw);
    chk(r == 16'h0005, "R5", "mode read", r, 16'h0005);

    // R6 compare/capture registers
    for (int i = 0; i < NCC; i++) acc(1, 10 + i, DW'(16'h0C00 + i), r, nw);
    for (int i = 0; i < NCC; i++) begin
      acc(0, 10 + i, 0, r, nw);
      chk(r == DW'(16'h0C00 + i), "R6", "cc read", r, 16'h0C00 + i);
      chk(core_cc[i*DW +: DW] == DW'(16'h0C00 + i), "R6", "cc core", core_cc[i*DW +: DW], 16'h0C00 + i);
    end

    // R10 unmapped
    acc(1, 15, 16'hFFFF, r, nw);
    chk(nw == 0, "R7", "unmapped no wait", nw, 0);
    acc(0, 15, 0, r, nw);
    chk(r == 0, "R10", "unmapped reads 0", r, 0);
    repeat (10) @(posedge cclk);
    chk(core_count == 16'hA003 && core_cfg == 16'h0F00 && core_mode == 5, "R10", "core unchanged", core_count, 16'hA003);

    // R9 enable and software reset
    acc(1, 0, 16'h0002, r, nw);
    idle();
    chk(core_enable == 1, "R9", "enable set", core_enable, 1);
    acc(0, 0, 0, r, nw);
    chk(r[1] == 1 && nw == 0, "R7", "ctrl read local", r, 2);
    exp_cnt_q.push_back('0);
    acc(1, 0, 16'h0001, r, nw);
    acc(0, 4, 0, r, nw);
    chk(r[0] == 1, "R9", "busy during reset", r[0], 1);
    idle();
    chk(core_enable == 0 && core_cfg == 0 && core_mode == 0 && core_period == 0,
        "R9", "core regs cleared", core_cfg, 0);
    chk(core_count == 0 && core_cc == 0, "R9", "count/cc cleared", core_count, 0);
    acc(0, 8, 0, r, nw);
    chk(r == 0, "R9", "count reads 0", r, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule